// File: doc/BRIEF.md
# Three-Wire Configuration Slave with Status Readback

This block is the device side of a three-wire configuration port. A host clocks words in on a serial data line, most significant bit first, using a serial clock. It then raises a latch-enable line, and the last 32 bits shifted in are stored in one of sixteen configuration registers. The low four bits of the word itself choose which register is written. All three host lines and the chip-enable line are oversampled by the system clock through synchronizers, so the whole block runs in one clock domain.

One register address is the readback control register. A word written there with its enable bit set takes a snapshot of one of several 16-bit status inputs, chosen by a select field in the same word. With latch enable still held high, the host then gives 18 serial clocks. The first clock produces a dummy bit, the next sixteen produce the snapshot MSB first, and the eighteenth releases the output. The tristate pin is modelled as a data output plus an output-enable.

Top module: `cfg3w_slave`

## Requirements
- R1: After reset all sixteen registers read zero and the readback output enable is low.
- R2: Each rising serial-clock edge shifts the serial data bit into the low end of a 32-bit shift register. A rising latch-enable edge copies the whole shift register into the register addressed by its bits [3:0].
- R3: A latch writes only the addressed register. All other registers keep their contents.
- R4: A 16-bit word can be written by giving only 16 clocks. The addressed register then holds the previous low 16 shifted bits in [31:16] and the new 16 bits in [15:0].
- R5: A readback is armed only when the latched word has address 7 (bits [3:0]) and bit 8 set. The word then returns status source number bits [5:4]. If bit 8 is clear, the output enable stays low through every later serial clock.
- R6: After an armed latch the output enable stays low until the first serial clock. The first clock drives enable high with a dummy 0. Clocks 2 to 17 drive the snapshot bits 15 down to 0. Clock 18 drives the enable low again.
- R7: The snapshot is taken at the arming latch edge. Changes on the status inputs during the readout do not alter the bits returned.
- R8: If latch enable falls during a readout, the output enable goes low and stays low for any further serial clocks.
- R9: While chip enable is low, serial clocks, data and latch edges are ignored, registers keep their values, and the readback output enable is forced low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable; interface inactive when low |
| sclk_i | input | 1 | Host serial clock |
| sdata_i | input | 1 | Host serial data, MSB first |
| sle_i | input | 1 | Host latch enable |
| status_i | input | 64 | Four 16-bit status sources, source n in bits [16n+15:16n] |
| latch_bank_o | output | 512 | Sixteen 32-bit registers, register n in bits [32n+31:32n] |
| rb_data_o | output | 1 | Readback serial data |
| rb_oe_o | output | 1 | Readback output enable (high = driven, low = high impedance) |

## Verification
The bench aims at the readback framing. A design off by one clock would return the dummy bit as bit 15, or would keep driving the pin after clock 18. A design that read the status inputs live would return corrupted bits, because the bench flips the source mid-readout. A missed abort on latch-enable fall would leave the pin driven. The bench also checks a 16-bit write, where a cleared shift register would lose the upper half. It writes with chip enable low, where a design without gating would overwrite register 5. It checks that writes to other addresses leave every other register alone.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  parameter int DEF_WORD_W   = 32;
  parameter int DEF_NREG     = 16;
  parameter int DEF_RB_W     = 16;
  parameter int DEF_NSRC     = 4;
  parameter int DEF_RB_ADDR  = 7;
  parameter int DEF_RB_EN    = 8;
  parameter int DEF_SEL_LSB  = 4;
  parameter int DEF_SYNC     = 2;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg3w_regbank.sv
module cfg3w_regbank #(
  parameter int WORD_W = 32,
  parameter int NREG   = 16,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_ev,
  input  logic                   sdata,
  input  logic                   latch_ev,
  output logic [WORD_W-1:0]      shreg_o,
  output logic [NREG*WORD_W-1:0] bank_o
);
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] bank_q [NREG];

  // shift register next state
  always_comb begin
    shreg_d = shreg_q;
    if (shift_ev) shreg_d = {shreg_q[WORD_W-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic wr_en;
      assign wr_en = latch_ev && (shreg_q[ADDR_W-1:0] == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank_q[g] <= '0;
        else if (wr_en) bank_q[g] <= shreg_q;
      end
      assign bank_o[g*WORD_W +: WORD_W] = bank_q[g];
    end
  endgenerate

  assign shreg_o = shreg_q;
endmodule

// File: rtl/cfg3w_readback.sv
module cfg3w_readback #(
  parameter int RB_W    = 16,
  parameter int NSRC    = 4,
  parameter int RB_ADDR = 7,
  parameter int ADDR_W  = 4,
  localparam int SEL_W  = $clog2(NSRC),
  localparam int CNT_W  = $clog2(RB_W + 2),
  localparam int LAST   = RB_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               clk_ev,
  input  logic               latch_ev,
  input  logic               sle_lvl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               en_bit,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NSRC*RB_W-1:0] status,
  output logic               data_o,
  output logic               oe_o
);
  logic [RB_W-1:0]  src [NSRC];
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RB_W-1:0]  word_q, word_d;
  logic             oe_q, oe_d;
  logic             dout_q, dout_d;
  logic             arm;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign src[g] = status[g*RB_W +: RB_W];
    end
  endgenerate

  assign arm = (addr == ADDR_W'(RB_ADDR)) && en_bit;

  // readback next state
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    word_d   = word_q;
    oe_d     = oe_q;
    dout_d   = dout_q;
    if (!ce || (active_q && !sle_lvl)) begin
      active_d = 1'b0;
      oe_d     = 1'b0;
      dout_d   = 1'b0;
    end else if (latch_ev) begin
      oe_d     = 1'b0;
      dout_d   = 1'b0;
      cnt_d    = '0;
      active_d = arm;
      if (arm) word_d = src[sel];
    end else if (active_q && clk_ev) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == '0) begin
        oe_d   = 1'b1;
        dout_d = 1'b0;
      end else if (cnt_q == CNT_W'(LAST)) begin
        oe_d     = 1'b0;
        dout_d   = 1'b0;
        active_d = 1'b0;
      end else begin
        dout_d = word_q[RB_W-1];
        word_d = {word_q[RB_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      word_q   <= '0;
      oe_q     <= 1'b0;
      dout_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      word_q   <= word_d;
      oe_q     <= oe_d;
      dout_q   <= dout_d;
    end
  end

  assign data_o = dout_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave
  import cfg3w_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int NREG    = DEF_NREG,
  parameter int RB_W    = DEF_RB_W,
  parameter int NSRC    = DEF_NSRC,
  parameter int RB_ADDR = DEF_RB_ADDR,
  parameter int RB_EN   = DEF_RB_EN,
  parameter int SEL_LSB = DEF_SEL_LSB,
  parameter int SYNC    = DEF_SYNC,
  localparam int ADDR_W = $clog2(NREG),
  localparam int SEL_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_i,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   sle_i,
  input  logic [NSRC*RB_W-1:0]   status_i,
  output logic [NREG*WORD_W-1:0] latch_bank_o,
  output logic                   rb_data_o,
  output logic                   rb_oe_o
);
  logic       rst_m_q, rst_q_n;
  logic [3:0] pins_s;
  logic       ce_s, sclk_s, sdata_s, sle_s;
  logic       sclk_d_q, sle_d_q;
  logic       shift_ev, latch_ev, sle_fall;
  logic [WORD_W-1:0] shreg;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  cfg3w_sync #(.W(4), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({ce_i, sclk_i, sdata_i, sle_i}),
    .q_o   (pins_s)
  );
  assign {ce_s, sclk_s, sdata_s, sle_s} = pins_s;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sclk_d_q <= 1'b0;
      sle_d_q  <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      sle_d_q  <= sle_s;
    end
  end

  assign shift_ev = ce_s && sclk_s && !sclk_d_q;
  assign latch_ev = ce_s && sle_s && !sle_d_q;
  assign sle_fall = !sle_s && sle_d_q;

  cfg3w_regbank #(.WORD_W(WORD_W), .NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .shift_ev (shift_ev),
    .sdata    (sdata_s),
    .latch_ev (latch_ev),
    .shreg_o  (shreg),
    .bank_o   (latch_bank_o)
  );

  cfg3w_readback #(.RB_W(RB_W), .NSRC(NSRC), .RB_ADDR(RB_ADDR), .ADDR_W(ADDR_W)) u_rb (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ce       (ce_s),
    .clk_ev   (shift_ev),
    .latch_ev (latch_ev),
    .sle_lvl  (sle_s),
    .addr     (shreg[ADDR_W-1:0]),
    .en_bit   (shreg[RB_EN]),
    .sel      (shreg[SEL_LSB +: SEL_W]),
    .status   (status_i),
    .data_o   (rb_data_o),
    .oe_o     (rb_oe_o)
  );
endmodule

// File: rtl/cfg3w_slave_chk.sv
module cfg3w_slave_chk #(
  parameter int BANK_W = 512,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              sle_s,
  input logic              shift_ev,
  input logic              latch_ev,
  input logic [WORD_W-1:0] shreg,
  input logic [BANK_W-1:0] bank,
  input logic              rb_oe,
  input logic              rb_data
);
  AST_BANK_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> $past(latch_ev)); // R3
  AST_SHIFT_ONLY_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> $past(shift_ev)); // R2
  AST_OE_RISES_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_oe) |-> $past(shift_ev)); // R6
  AST_DUMMY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_oe) |-> !rb_data); // R6
  AST_ABORT_ON_SLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_oe && !sle_s) |=> !rb_oe); // R8
  AST_CE_FREEZES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> ($stable(bank) && !rb_oe)); // R9
endmodule

bind cfg3w_slave cfg3w_slave_chk #(.BANK_W(NREG*WORD_W), .WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .ce_s     (ce_s),
  .sle_s    (sle_s),
  .shift_ev (shift_ev),
  .latch_ev (latch_ev),
  .shreg    (shreg),
  .bank     (latch_bank_o),
  .rb_oe    (rb_oe_o),
  .rb_data  (rb_data_o)
);

// File: tb/cfg3w_slave_tb.sv
module cfg3w_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ce, sclk, sdata, sle;
  logic [63:0] status;
  logic [511:0] bank;
  logic rb_data, rb_oe;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg3w_slave dut_i (
    .clk (clk), .rst_n (rst_n), .ce_i (ce), .sclk_i (sclk), .sdata_i (sdata),
    .sle_i (sle), .status_i (status), .latch_bank_o (bank),
    .rb_data_o (rb_data), .rb_oe_o (rb_oe)
  );

  localparam logic [31:0] WR_TAB [16] = '{
    32'hA1B2_C3D0, 32'h0F0F_0F01, 32'hFFFF_FFF2, 32'h1357_9BD3,
    32'h8000_0004, 32'h2468_ACE5, 32'h5555_5556, 32'h0000_0007,
    32'hDEAD_BEE8, 32'h7FFF_FFF9, 32'hC0FF_EE0A, 32'h0123_456B,
    32'h9999_999C, 32'hFACE_B00D, 32'h3141_592E, 32'hCAFE_F00F
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_n(8); sclk = 1'b0; wait_n(8);
  endtask

  task automatic shift_word(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = w[i]; wait_n(4);
      sclk = 1'b1; wait_n(8);
      sclk = 1'b0; wait_n(4);
    end
  endtask

  task automatic write_word(input logic [31:0] w, input int nbits);
    shift_word(w, nbits);
    sle = 1'b1; wait_n(8); sle = 1'b0; wait_n(8);
  endtask

  function automatic logic [31:0] slot(input int a);
    return bank[a*32 +: 32];
  endfunction

  // readback pulse with sampling 6 clocks after the rise
  task automatic rb_pulse(output logic d, output logic oe);
    sclk = 1'b1; wait_n(6); d = rb_data; oe = rb_oe; wait_n(2);
    sclk = 1'b0; wait_n(8);
  endtask

  task automatic readback(input int sel, input bit mutate, input string req);
    logic [15:0] exp, got;
    logic d, oe;
    exp = status[sel*16 +: 16];
    shift_word(32'h0000_0107 | (32'(sel) << 4), 32);
    sle = 1'b1; wait_n(8);
    chk(rb_oe == 1'b0, "R6 idle before first clock", 64'(rb_oe), 64'd0);
    rb_pulse(d, oe);
    chk(oe == 1'b1 && d == 1'b0, "R6 dummy bit", {62'd0, oe, d}, 64'd2);
    if (mutate) status[sel*16 +: 16] = ~exp;
    for (int i = 15; i >= 0; i--) begin
      rb_pulse(d, oe);
      got[i] = d;
    end
    chk(got == exp, req, 64'(got), 64'(exp));
    rb_pulse(d, oe);
    chk(oe == 1'b0, "R6 release on clock 18", 64'(oe), 64'd0);
    sle = 1'b0; wait_n(8);
    if (mutate) status[sel*16 +: 16] = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic d, oe;
    logic [511:0] snap;
    rst_n = 1'b0; ce = 1'b1; sclk = 1'b0; sdata = 1'b0; sle = 1'b0;
    status = {16'h7FFE, 16'h8001, 16'h1234, 16'hBEEF};
    wait_n(10); rst_n = 1'b1; wait_n(10);

    // R1 reset state
    chk(bank == '0 && rb_oe == 1'b0, "R1 reset", {63'd0, rb_oe}, 64'd0);

    // R2 table walk
    for (int a = 0; a < 16; a++) begin
      write_word(WR_TAB[a], 32);
      chk(slot(a) == WR_TAB[a], "R2 latch write", 64'(slot(a)), 64'(WR_TAB[a]));
    end
    // R3 nothing else disturbed
    for (int a = 0; a < 16; a++)
      chk(slot(a) == WR_TAB[a], "R3 other registers kept", 64'(slot(a)), 64'(WR_TAB[a]));

    // R4 16-bit write
    write_word(32'h1234_5673, 32);
    write_word(32'h0000_A5C3, 16);
    chk(slot(3) == 32'h5673_A5C3, "R4 short word", 64'(slot(3)), 64'h5673_A5C3);

    // R9 write ignored with chip enable low
    ce = 1'b0; wait_n(8);
    write_word(32'h0BAD_0005, 32);
    chk(slot(5) == WR_TAB[5], "R9 write ignored", 64'(slot(5)), 64'(WR_TAB[5]));
    ce = 1'b1; wait_n(8);

    // R5 readback per source, R7 snapshot
    readback(0, 1'b0, "R5 source 0");
    readback(1, 1'b0, "R5 source 1");
    readback(2, 1'b1, "R7 snapshot held");
    readback(3, 1'b0, "R5 source 3");

    // R5 enable bit clear
    shift_word(32'h0000_0027, 32);
    sle = 1'b1; wait_n(8);
    rb_pulse(d, oe);
    chk(oe == 1'b0, "R5 no enable clock 1", 64'(oe), 64'd0);
    rb_pulse(d, oe);
    chk(oe == 1'b0, "R5 no enable clock 2", 64'(oe), 64'd0);
    sle = 1'b0; wait_n(8);

    // R8 abort on latch enable fall
    shift_word(32'h0000_0117, 32);
    sle = 1'b1; wait_n(8);
    for (int i = 0; i < 4; i++) rb_pulse(d, oe);
    chk(oe == 1'b1, "R8 driving before abort", 64'(oe), 64'd1);
    sle = 1'b0; wait_n(8);
    chk(rb_oe == 1'b0, "R8 abort", 64'(rb_oe), 64'd0);
    rb_pulse(d, oe);
    chk(oe == 1'b0, "R8 stays released", 64'(oe), 64'd0);

    // R9 chip enable low during readout
    shift_word(32'h0000_0107, 32);
    sle = 1'b1; wait_n(8);
    for (int i = 0; i < 3; i++) rb_pulse(d, oe);
    snap = bank;
    ce = 1'b0; wait_n(8);
    chk(rb_oe == 1'b0, "R9 readout forced off", 64'(rb_oe), 64'd0);
    sle = 1'b0; wait_n(8);
    chk(bank == snap, "R9 bank kept", 64'(slot(7)), 64'(snap[7*32 +: 32]));
    ce = 1'b1; wait_n(8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule